// File: doc/BRIEF.md
# Radio Frame Transmit Sequencer

This block sequences the sending of one frame in the digital back end of a packet radio. A host loads frame bytes through a byte-wide buffer port. The bytes land at consecutive buffer positions starting at position zero. The host controls the block through a small register set: a state register that takes commands and reports the current state, a control register that selects the payload bit rate, and an interrupt status register.

A transmission starts on a rising edge of a dedicated start pin, or when the start command is written to the state register. Either way it is taken only when the block sits in one of its two ready states. The block then waits out a synthesizer settling time and sends a fixed synchronization header that it generates itself. After that it reads the length byte and the payload from the buffer and shifts them out LSB first as a serial bit stream with a strobe.

The host may keep writing the buffer after transmission has begun. The sequencer compares its read position against the number of bytes written. When it would read a byte that is not there yet, it aborts the frame and raises an underrun flag. Completion raises an end flag instead. Both flags drive one interrupt pin, and reading the status register clears them.

Top module: `tx_frame_seq`

## Requirements
- R1: After reset the state register (address 0x02) reads 0x08 (off), `irq` and `tx_busy` are low, and the interrupt status register (address 0x0F) reads 0x00.
- R2: A rising edge on `start_pin` starts a transmission only in the ready states 0x09 or 0x19. In state 0x08, or while a frame is in progress, the edge has no effect on `tx_busy` or on the bit stream.
- R3: Writing 0x02 to address 0x02 starts a transmission from a ready state and is ignored in state 0x08. Writing 0x08, 0x09 or 0x19 while idle moves the block to off, ready (0x09) or ready-with-retry (0x19).
- R4: The first header bit strobes 16 µs after the start is accepted. The header is 40 bits of 4 µs each: 32 zero bits followed by 0xA7 sent LSB first. The first length-byte bit therefore strobes 176 µs after acceptance.
- R5: The length byte (buffer position 0) is sent first. Its low 7 bits give the number of payload bytes that follow. Every byte is sent LSB first, with one `tx_strobe` pulse per bit.
- R6: Bits 1:0 of the control register (address 0x0C) select the length and payload bit time: 0 gives 4 µs, 1 gives 2 µs, 2 or 3 give 1 µs. The value is taken when the start is accepted, and later writes do not change the running frame.
- R7: If the buffer holds no byte when the header ends, the frame aborts after exactly 40 bits. Status bit 6 is set, bit 3 is not, and the state returns to 0x09.
- R8: If the next byte to send has not been written, sending stops after the current byte. Status bit 6 is set, bit 3 is not, and the state returns to 0x09.
- R9: Buffer writes made while a frame is in progress are sent in that frame, provided each byte arrives before its turn.
- R10: After the last payload bit the block sets status bit 3, deasserts `tx_busy` and returns to state 0x09. The buffer then counts as empty, and the next write goes to position 0.
- R11: `irq` is high while any status bit is set. A read of address 0x0F returns the pending bits on `reg_rdata` one cycle later and clears them, and `irq` falls with that clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLK_MHZ` MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pin | input | 1 | Start request, rising edge |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after `reg_rd_en` |
| fb_wr_en | input | 1 | Frame buffer byte write strobe |
| fb_wr_data | input | 8 | Frame buffer byte |
| tx_bit | output | 1 | Serial transmit bit |
| tx_strobe | output | 1 | One-cycle pulse when `tx_bit` takes a new bit |
| tx_busy | output | 1 | High from start acceptance until end or abort |
| irq | output | 1 | Interrupt, high while a status bit is pending |

## Verification
The case hardest to reach from the ports is a buffer race in progress: the read position has to catch the write count at a chosen byte, and in another run it must stay just behind it. The stimulus loads only the length byte and one payload byte before starting, then stops writing, so the abort falls at a known bit count. In a separate frame it writes the remaining payload only after the length-byte bits have begun to strobe, so the bytes arrive after the frame is under way yet ahead of their turn. A start made with an empty buffer, right after an abort has emptied it, covers the missing length byte at the end of the header.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_READY,
    ST_READY_RETRY,
    ST_SETTLE,
    ST_HEADER,
    ST_PAYLOAD
  } seq_state_t;

  localparam logic [7:0] CODE_OFF         = 8'h08;
  localparam logic [7:0] CODE_READY       = 8'h09;
  localparam logic [7:0] CODE_READY_RETRY = 8'h19;
  localparam logic [7:0] CODE_BUSY        = 8'h02;
  localparam logic [7:0] CMD_START        = 8'h02;

  localparam logic [5:0] ADDR_STATE = 6'h02;
  localparam logic [5:0] ADDR_CTRL  = 6'h0C;
  localparam logic [5:0] ADDR_IRQ   = 6'h0F;

  localparam int unsigned IRQ_END_POS = 3;
  localparam int unsigned IRQ_UR_POS  = 6;

  localparam logic [7:0]  SYNC_WORD    = 8'hA7;
  localparam int unsigned HDR_ZEROS    = 32;
  localparam int unsigned HDR_BITS     = 40;
  localparam int unsigned SETTLE_US    = 16;
  localparam int unsigned HDR_BIT_US   = 4;

endpackage

// File: rtl/tfs_tick.sv
module tfs_tick #(
  parameter int unsigned CLK_MHZ = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_MHZ - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the microsecond divider never leaves its range
  a_r4_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/tfs_fbuf.sv
module tfs_fbuf #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned AW1 = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  input  logic           clear,
  input  logic [AW-1:0]  rd_idx,
  output logic [7:0]     rd_data,
  output logic [AW1-1:0] fill
);
  localparam logic [AW1-1:0] DEPTH_V = AW1'(DEPTH);

  logic [7:0]     mem [DEPTH];
  logic [AW1-1:0] fill_q, fill_d;
  logic [AW-1:0]  wr_idx;
  logic           has_room;
  logic           do_write;

  assign wr_idx   = clear ? '0 : fill_q[AW-1:0];
  assign has_room = clear || (fill_q < DEPTH_V);
  assign do_write = wr_en && has_room;
  assign rd_data  = mem[rd_idx];
  assign fill     = fill_q;

  always_comb begin
    if (clear)         fill_d = do_write ? AW1'(1) : '0;
    else if (do_write) fill_d = fill_q + AW1'(1);
    else               fill_d = fill_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  always_ff @(posedge clk) begin
    if (do_write) mem[wr_idx] <= wr_data;
  end

  // R9: fill level never exceeds the storage
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= DEPTH_V);

  // R10: a clear without a write leaves the buffer empty
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !wr_en) |=> (fill_q == '0));

endmodule

// File: rtl/tfs_regs.sv
module tfs_regs
  import tfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic       reg_rd_en,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic [7:0] state_code,
  input  logic       set_end,
  input  logic       set_ur,
  output logic [7:0] reg_rdata,
  output logic [1:0] rate_cfg,
  output logic       cmd_valid,
  output logic [7:0] cmd_code,
  output logic       irq
);
  logic [7:0] ctrl_q, ctrl_d;
  logic       end_q, end_d, ur_q, ur_d;
  logic [7:0] rdata_q, rdata_d;
  logic       ctrl_we, irq_rd;
  logic [7:0] irq_byte;

  assign ctrl_we   = reg_wr_en && (reg_addr == ADDR_CTRL);
  assign irq_rd    = reg_rd_en && (reg_addr == ADDR_IRQ);
  assign cmd_valid = reg_wr_en && (reg_addr == ADDR_STATE);
  assign cmd_code  = reg_wdata;
  assign rate_cfg  = ctrl_q[1:0];
  assign irq       = end_q || ur_q;

  always_comb begin
    irq_byte = '0;
    irq_byte[IRQ_END_POS] = end_q;
    irq_byte[IRQ_UR_POS]  = ur_q;
  end

  always_comb begin
    ctrl_d = ctrl_we ? reg_wdata : ctrl_q;
    end_d  = (end_q && !irq_rd) || set_end;
    ur_d   = (ur_q && !irq_rd) || set_ur;
    case (reg_addr)
      ADDR_STATE: rdata_d = state_code;
      ADDR_CTRL:  rdata_d = ctrl_q;
      ADDR_IRQ:   rdata_d = irq_byte;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      end_q   <= 1'b0;
      ur_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      end_q  <= end_d;
      ur_q   <= ur_d;
      if (reg_rd_en) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;

  // R11: a status read with no new event leaves the interrupt low
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && !set_end && !set_ur) |=> !irq);

  // R11: an event always shows on the interrupt pin next cycle
  a_r11_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (set_end || set_ur) |=> irq);

endmodule

// File: rtl/tfs_seq.sv
module tfs_seq
  import tfs_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned AW1 = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start_pin,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_code,
  input  logic [1:0]     rate_cfg,
  input  logic [AW1-1:0] fill,
  input  logic [7:0]     rd_data,
  output logic           tick_restart,
  output logic [AW-1:0]  rd_idx,
  output logic           fb_clear,
  output logic [7:0]     state_code,
  output logic           tx_bit,
  output logic           tx_strobe,
  output logic           tx_busy,
  output logic           set_end,
  output logic           set_ur
);
  seq_state_t     st_q, st_d;
  logic [3:0]     us_q, us_d;
  logic [5:0]     bit_q, bit_d;
  logic [AW1-1:0] byte_q, byte_d;
  logic [AW1-1:0] total_q, total_d;
  logic [7:0]     shift_q, shift_d;
  logic [1:0]     rate_q, rate_d;
  logic           txb_q, txb_d;
  logic           stb_q, stb_d;
  logic           pin_q;

  logic           pin_rise, start_req, ready, accept;
  logic [3:0]     per_m1;
  logic           bit_end;
  logic [AW1-1:0] nxt_byte;

  function automatic logic hdr_bit(input logic [5:0] idx);
    if (idx < 6'(HDR_ZEROS)) return 1'b0;
    return SYNC_WORD[idx[2:0]];
  endfunction

  assign pin_rise  = start_pin && !pin_q;
  assign start_req = pin_rise || (cmd_valid && (cmd_code == CMD_START));
  assign ready     = (st_q == ST_READY) || (st_q == ST_READY_RETRY);
  assign accept    = start_req && ready;
  assign tick_restart = accept;
  assign nxt_byte  = byte_q + AW1'(1);

  always_comb begin
    if (st_q == ST_HEADER) per_m1 = 4'(HDR_BIT_US - 1);
    else begin
      case (rate_q)
        2'd0:    per_m1 = 4'd3;
        2'd1:    per_m1 = 4'd1;
        default: per_m1 = 4'd0;
      endcase
    end
  end

  assign bit_end = tick && (us_q == per_m1);

  always_comb begin
    st_d     = st_q;
    us_d     = tick ? us_q + 4'd1 : us_q;
    bit_d    = bit_q;
    byte_d   = byte_q;
    total_d  = total_q;
    shift_d  = shift_q;
    rate_d   = rate_q;
    txb_d    = txb_q;
    stb_d    = 1'b0;
    set_end  = 1'b0;
    set_ur   = 1'b0;
    fb_clear = 1'b0;
    rd_idx   = '0;
    case (st_q)
      ST_OFF, ST_READY, ST_READY_RETRY: begin
        if (accept) begin
          st_d   = ST_SETTLE;
          us_d   = '0;
          rate_d = rate_cfg;
        end else if (cmd_valid) begin
          case (cmd_code)
            CODE_OFF:         st_d = ST_OFF;
            CODE_READY:       st_d = ST_READY;
            CODE_READY_RETRY: st_d = ST_READY_RETRY;
            default:          st_d = st_q;
          endcase
        end
      end
      ST_SETTLE: begin
        if (tick && (us_q == 4'(SETTLE_US - 1))) begin
          st_d  = ST_HEADER;
          us_d  = '0;
          bit_d = '0;
          txb_d = hdr_bit(6'd0);
          stb_d = 1'b1;
        end
      end
      ST_HEADER: begin
        if (bit_end) begin
          us_d = '0;
          if (bit_q == 6'(HDR_BITS - 1)) begin
            if (fill == '0) begin
              set_ur   = 1'b1;
              fb_clear = 1'b1;
              st_d     = ST_READY;
              txb_d    = 1'b0;
            end else begin
              shift_d = rd_data;
              total_d = AW1'(rd_data[6:0]) + AW1'(1);
              byte_d  = '0;
              bit_d   = '0;
              txb_d   = rd_data[0];
              stb_d   = 1'b1;
              st_d    = ST_PAYLOAD;
            end
          end else begin
            bit_d = bit_q + 6'd1;
            txb_d = hdr_bit(bit_q + 6'd1);
            stb_d = 1'b1;
          end
        end
      end
      ST_PAYLOAD: begin
        if (bit_end) begin
          us_d = '0;
          if (bit_q == 6'd7) begin
            if (nxt_byte == total_q) begin
              set_end  = 1'b1;
              fb_clear = 1'b1;
              st_d     = ST_READY;
              txb_d    = 1'b0;
            end else if (nxt_byte >= fill) begin
              set_ur   = 1'b1;
              fb_clear = 1'b1;
              st_d     = ST_READY;
              txb_d    = 1'b0;
            end else begin
              rd_idx  = nxt_byte[AW-1:0];
              shift_d = rd_data;
              txb_d   = rd_data[0];
              bit_d   = '0;
              byte_d  = nxt_byte;
              stb_d   = 1'b1;
            end
          end else begin
            bit_d   = bit_q + 6'd1;
            shift_d = shift_q >> 1;
            txb_d   = shift_q[1];
            stb_d   = 1'b1;
          end
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      us_q    <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      total_q <= '0;
      shift_q <= '0;
      rate_q  <= '0;
      txb_q   <= 1'b0;
      stb_q   <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      us_q    <= us_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      total_q <= total_d;
      shift_q <= shift_d;
      rate_q  <= rate_d;
      txb_q   <= txb_d;
      stb_q   <= stb_d;
      pin_q   <= start_pin;
    end
  end

  assign tx_bit    = txb_q;
  assign tx_strobe = stb_q;
  assign tx_busy   = (st_q == ST_SETTLE) || (st_q == ST_HEADER) || (st_q == ST_PAYLOAD);

  always_comb begin
    case (st_q)
      ST_OFF:         state_code = CODE_OFF;
      ST_READY:       state_code = CODE_READY;
      ST_READY_RETRY: state_code = CODE_READY_RETRY;
      default:        state_code = CODE_BUSY;
    endcase
  end

  // R2: a frame only begins from one of the two ready states
  a_r2_start_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> ($past(st_q) == ST_READY || $past(st_q) == ST_READY_RETRY));

  // R8: end and underrun are never raised together
  a_r8_end_xor_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_end && set_ur));

  // R7: after an abort no further bit is strobed
  a_r7_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    set_ur |=> (!tx_strobe && !tx_busy));

  // R10: completion returns to the ready state
  a_r10_end_to_ready: assert property (@(posedge clk) disable iff (!rst_n)
    set_end |=> (st_q == ST_READY && !tx_busy));

  // R9: a payload byte is only taken from a written position
  a_r9_read_written: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAYLOAD && stb_d && bit_d == '0) |-> (nxt_byte < fill));

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tfs_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 125,
  parameter int unsigned FB_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_pin,
  input  logic       reg_wr_en,
  input  logic       reg_rd_en,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       fb_wr_en,
  input  logic [7:0] fb_wr_data,
  output logic       tx_bit,
  output logic       tx_strobe,
  output logic       tx_busy,
  output logic       irq
);
  localparam int unsigned AW  = $clog2(FB_DEPTH);
  localparam int unsigned AW1 = AW + 1;

  logic [1:0]     rst_sync_q;
  logic           core_rst_n;
  logic           tick, tick_restart;
  logic [AW-1:0]  rd_idx;
  logic [7:0]     rd_data;
  logic [AW1-1:0] fill;
  logic           fb_clear;
  logic [7:0]     state_code;
  logic           set_end, set_ur;
  logic [1:0]     rate_cfg;
  logic           cmd_valid;
  logic [7:0]     cmd_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  tfs_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .restart (tick_restart),
    .tick    (tick)
  );

  tfs_fbuf #(.DEPTH(FB_DEPTH)) u_fbuf (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (fb_wr_en),
    .wr_data (fb_wr_data),
    .clear   (fb_clear),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .fill    (fill)
  );

  tfs_regs u_regs (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .state_code (state_code),
    .set_end    (set_end),
    .set_ur     (set_ur),
    .reg_rdata  (reg_rdata),
    .rate_cfg   (rate_cfg),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .irq        (irq)
  );

  tfs_seq #(.DEPTH(FB_DEPTH)) u_seq (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .tick         (tick),
    .start_pin    (start_pin),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .rate_cfg     (rate_cfg),
    .fill         (fill),
    .rd_data      (rd_data),
    .tick_restart (tick_restart),
    .rd_idx       (rd_idx),
    .fb_clear     (fb_clear),
    .state_code   (state_code),
    .tx_bit       (tx_bit),
    .tx_strobe    (tx_strobe),
    .tx_busy      (tx_busy),
    .set_end      (set_end),
    .set_ur       (set_ur)
  );

  // R1: out of reset the block is idle with nothing pending
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (!tx_busy && !irq));

endmodule

// File: tb/tb_tx_frame_seq.sv
module tb_tx_frame_seq;
  localparam int unsigned MHZ = 4;

  logic       clk;
  logic       rst_n;
  logic       start_pin;
  logic       reg_wr_en, reg_rd_en;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       fb_wr_en;
  logic [7:0] fb_wr_data;
  logic       tx_bit, tx_strobe, tx_busy, irq;

  tx_frame_seq #(.CLK_MHZ(MHZ), .FB_DEPTH(128)) dut (
    .clk(clk), .rst_n(rst_n), .start_pin(start_pin),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fb_wr_en(fb_wr_en), .fb_wr_data(fb_wr_data),
    .tx_bit(tx_bit), .tx_strobe(tx_strobe), .tx_busy(tx_busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int nb    = 0;
  logic       cap_bit [4096];
  int         cap_t   [4096];
  logic [7:0] exp_b   [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_strobe && nb < 4096) begin
      cap_bit[nb] = tx_bit;
      cap_t[nb]   = cyc;
      nb = nb + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic fb_write(input logic [7:0] d);
    @(negedge clk);
    fb_wr_en = 1'b1; fb_wr_data = d;
    @(negedge clk);
    fb_wr_en = 1'b0;
  endtask

  task automatic pin_start(output int t0);
    @(negedge clk);
    start_pin = 1'b1; t0 = cyc;
    @(negedge clk);
    @(negedge clk);
    start_pin = 1'b0;
  endtask

  task automatic cmd_start(output int t0);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 6'h02; reg_wdata = 8'h02; t0 = cyc;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20000 && tx_busy; n++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // compare captured bits from index b0: header plus nbytes of exp_b
  task automatic check_bits(input int b0, input int nbytes, input string req);
    int errs = 0;
    int first = -1;
    for (int i = 0; i < 40; i++) begin
      logic e = (i < 32) ? 1'b0 : ((8'hA7 >> (i - 32)) & 8'h01) != 0;
      if (cap_bit[b0 + i] !== e) begin errs++; if (first < 0) first = i; end
    end
    for (int j = 0; j < nbytes; j++) begin
      for (int k = 0; k < 8; k++) begin
        if (cap_bit[b0 + 40 + j*8 + k] !== exp_b[j][k]) begin
          errs++; if (first < 0) first = 40 + j*8 + k;
        end
      end
    end
    chk(errs == 0, req, first, -1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_pin = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    reg_addr = '0; reg_wdata = '0; fb_wr_en = 1'b0; fb_wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk(tx_busy == 1'b0, "R1 busy", tx_busy, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    reg_read(6'h02, d); chk(d == 8'h08, "R1 state", d, 8'h08);
    reg_read(6'h0F, d); chk(d == 8'h00, "R1 status", d, 0);
  endtask

  task automatic t_ignored_when_off();
    logic [7:0] d;
    int t0;
    int b0 = nb;
    pin_start(t0);
    cmd_start(t0);
    repeat (100) @(negedge clk);
    chk(tx_busy == 1'b0 && nb == b0, "R2 start ignored in off", nb - b0, 0);
    reg_read(6'h02, d); chk(d == 8'h08, "R3 start cmd ignored in off", d, 8'h08);
    reg_write(6'h02, 8'h09);
    reg_read(6'h02, d); chk(d == 8'h09, "R3 ready command", d, 8'h09);
  endtask

  task automatic t_pin_frame_slow();
    logic [7:0] d;
    int t0;
    int b0;
    exp_b[0] = 8'h02; exp_b[1] = 8'h5A; exp_b[2] = 8'hC3;
    reg_write(6'h0C, 8'h00);
    for (int i = 0; i < 3; i++) fb_write(exp_b[i]);
    b0 = nb;
    pin_start(t0);
    chk(tx_busy == 1'b1, "R2 pin start accepted", tx_busy, 1);
    wait_idle();
    chk(nb - b0 == 64, "R5 bit count", nb - b0, 64);
    chk(cap_t[b0] - t0 == 16*MHZ + 1, "R4 settle time", cap_t[b0] - t0, 16*MHZ + 1);
    chk(cap_t[b0+40] - t0 == 176*MHZ + 1, "R4 length byte time", cap_t[b0+40] - t0, 176*MHZ + 1);
    chk(cap_t[b0+1] - cap_t[b0] == 4*MHZ, "R4 header bit time", cap_t[b0+1] - cap_t[b0], 4*MHZ);
    chk(cap_t[b0+41] - cap_t[b0+40] == 4*MHZ, "R6 rate 0 bit time", cap_t[b0+41] - cap_t[b0+40], 4*MHZ);
    check_bits(b0, 3, "R5 header and payload bits");
    chk(irq == 1'b1, "R11 irq raised", irq, 1);
    reg_read(6'h0F, d); chk(d == 8'h08, "R10 end flag", d, 8'h08);
    chk(irq == 1'b0, "R11 irq cleared by read", irq, 0);
    reg_read(6'h0F, d); chk(d == 8'h00, "R11 status empty after read", d, 0);
    reg_read(6'h02, d); chk(d == 8'h09, "R10 back to ready", d, 8'h09);
  endtask

  task automatic t_cmd_frame_fast();
    logic [7:0] d;
    int t0;
    int b0;
    exp_b[0] = 8'h03; exp_b[1] = 8'hF0; exp_b[2] = 8'h0F; exp_b[3] = 8'h81;
    reg_write(6'h02, 8'h19);
    reg_read(6'h02, d); chk(d == 8'h19, "R3 retry-ready command", d, 8'h19);
    reg_write(6'h0C, 8'h02);
    for (int i = 0; i < 4; i++) fb_write(exp_b[i]);
    b0 = nb;
    cmd_start(t0);
    chk(tx_busy == 1'b1, "R3 command start accepted", tx_busy, 1);
    while (nb < b0 + 45) @(negedge clk);
    @(negedge clk); start_pin = 1'b1;
    @(negedge clk); start_pin = 1'b0;
    wait_idle();
    chk(nb - b0 == 72, "R2 start while busy ignored", nb - b0, 72);
    chk(cap_t[b0+41] - cap_t[b0+40] == MHZ, "R6 rate 2 bit time", cap_t[b0+41] - cap_t[b0+40], MHZ);
    check_bits(b0, 4, "R5 fast frame bits");
    reg_read(6'h0F, d); chk(d == 8'h08, "R10 end flag fast", d, 8'h08);
    reg_read(6'h02, d); chk(d == 8'h09, "R10 retry state returns to ready", d, 8'h09);
  endtask

  task automatic t_overlap_write();
    logic [7:0] d;
    int t0;
    int b0;
    exp_b[0] = 8'h04; exp_b[1] = 8'h11; exp_b[2] = 8'h22; exp_b[3] = 8'h44; exp_b[4] = 8'h88;
    reg_write(6'h0C, 8'h01);
    fb_write(exp_b[0]);
    b0 = nb;
    pin_start(t0);
    reg_write(6'h0C, 8'h02);
    while (nb < b0 + 41) @(negedge clk);
    for (int i = 1; i < 5; i++) fb_write(exp_b[i]);
    wait_idle();
    chk(nb - b0 == 80, "R9 overlapped frame length", nb - b0, 80);
    check_bits(b0, 5, "R9 overlapped frame bits");
    chk(cap_t[b0+79] - cap_t[b0+78] == 2*MHZ, "R6 rate latched at start", cap_t[b0+79] - cap_t[b0+78], 2*MHZ);
    reg_read(6'h0F, d); chk(d == 8'h08, "R9 end flag", d, 8'h08);
  endtask

  task automatic t_underrun_mid();
    logic [7:0] d;
    int t0;
    int b0;
    exp_b[0] = 8'h05; exp_b[1] = 8'h3C;
    fb_write(exp_b[0]);
    fb_write(exp_b[1]);
    b0 = nb;
    pin_start(t0);
    wait_idle();
    chk(nb - b0 == 56, "R8 stops after written bytes", nb - b0, 56);
    check_bits(b0, 2, "R8 bits before abort");
    reg_read(6'h0F, d); chk(d == 8'h40, "R8 underrun flag only", d, 8'h40);
    reg_read(6'h02, d); chk(d == 8'h09, "R8 back to ready", d, 8'h09);
  endtask

  task automatic t_missing_length();
    logic [7:0] d;
    int t0;
    int b0 = nb;
    pin_start(t0);
    wait_idle();
    chk(nb - b0 == 40, "R7 only header sent", nb - b0, 40);
    check_bits(b0, 0, "R7 header bits");
    chk(irq == 1'b1, "R7 irq on missing length", irq, 1);
    reg_read(6'h0F, d); chk(d == 8'h40, "R7 underrun flag only", d, 8'h40);
    reg_read(6'h02, d); chk(d == 8'h09, "R7 back to ready", d, 8'h09);
  endtask

  bit done = 0;

  initial begin
    do_reset();
    t_reset_state();
    t_ignored_when_off();
    t_pin_frame_slow();
    t_cmd_frame_fast();
    t_overlap_write();
    t_underrun_mid();
    t_missing_length();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule